// File: doc/BRIEF.md
# Debug Port Activation Sequencer

This block decides when a two-wire debug port wakes up. The port has a clock pin, which doubles as the chip's reset pin, and a data pin. The data pin has a pull-down, so an undriven data pin reads as 0. An external tool activates the port in three steps:

1. It holds the data line high long enough to count as a deliberate request. The block then switches off the reset function of the shared pin.
2. Within a bounded window, the tool starts toggling the debug clock.
3. It keeps data high across a fixed number of rising clock edges. The port is then declared enabled.

A clock that goes quiet for too long drops everything back to reset mode, from any point in the sequence.

All timing runs on a free-running system clock, and every limit is a parameter counted in system-clock cycles. The two pins and the reset-sense level each pass through a two-flop synchroniser. Debug-clock rising edges are found in the system-clock domain. When the port becomes enabled, the block captures the reset-sense level into a register that stops the processor from running code.

The sequencer has five states:

| State | Meaning | Leaves for |
|---|---|---|
| `ST_RESET_MODE` | Reset function active | `ST_HOLD` when data goes high |
| `ST_HOLD` | Timing the data-high request | `ST_ARMED` after the hold time; `ST_RESET_MODE` if data drops |
| `ST_ARMED` | Reset off, waiting for the first clock edge | `ST_COUNT` on that edge; `ST_RESET_MODE` on window expiry or data low |
| `ST_COUNT` | Counting edges | `ST_ENABLED` on the last edge; `ST_RESET_MODE` on inactivity or data low |
| `ST_ENABLED` | Port active | `ST_RESET_MODE` on inactivity only |

Top module: `dbg_port_activator`

## Requirements
- R1: After system reset, `reset_function_enable` is 1, `interface_enabled` is 0 and `sampled_reset` is 0.
- R2: `reset_function_enable` falls only after the synchronised data line has been high for `HOLD_CYCLES` consecutive system cycles in `ST_HOLD`. A shorter high pulse leaves it at 1.
- R3: Once reset mode is off, `interface_enabled` rises on the `EDGE_TARGET`-th (default 16) debug-clock rising edge seen with data high. One edge fewer leaves it at 0.
- R4: If no debug-clock rising edge arrives within `START_WINDOW` cycles of entering `ST_ARMED`, the block returns to `ST_RESET_MODE` and `reset_function_enable` goes back to 1.
- R5: Data low in `ST_ARMED` or `ST_COUNT` aborts activation: `reset_function_enable` returns to 1 and `interface_enabled` stays 0.
- R6: In `ST_COUNT` or `ST_ENABLED`, a run of `IDLE_LIMIT` cycles without a rising edge returns the block to `ST_RESET_MODE`. An edge arriving in the very cycle the limit expires wins and keeps the sequence alive.
- R7: On entry to `ST_ENABLED`, `sampled_reset` takes the synchronised reset-sense level. It is 0 whenever the port is not enabled.
- R8: In `ST_ENABLED`, the data line may toggle freely without disabling the port.
- R9: `reset_function_enable` and `interface_enabled` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| dbg_clk_pin | input | 1 | Debug clock pin (shared with reset), asynchronous |
| dbg_data_pin | input | 1 | Debug data pin level; undriven reads as 0 |
| rst_sense_pin | input | 1 | Reset-sense level sampled on enabling, asynchronous |
| reset_function_enable | output | 1 | 1 while the shared pin acts as reset |
| interface_enabled | output | 1 | 1 while the debug port is active |
| sampled_reset | output | 1 | Reset-sense level captured at enabling |

## Verification
Two events can land in the same system cycle: a debug-clock rising edge, and expiry of the inactivity or start-window timer. The design gives the edge priority. The bench provokes the collision by spacing clock pulses exactly `IDLE_LIMIT` system cycles apart, which puts every detected edge on the expiry cycle. It expects the port to reach and hold the enabled state. It then spaces the pulses one cycle wider and expects the port never to enable.

// File: rtl/dap_pkg.sv
package dap_pkg;

    typedef enum logic [2:0] {
        ST_RESET_MODE = 3'd0,
        ST_HOLD       = 3'd1,
        ST_ARMED      = 3'd2,
        ST_COUNT      = 3'd3,
        ST_ENABLED    = 3'd4
    } dap_state_e;

endpackage

// File: rtl/dap_sync.sv
// Multi-bit, multi-stage synchroniser; reset value 0 matches the pull-down idle.
module dap_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dap_rise.sv
// Rising-edge detector on an already synchronised level.
module dap_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;

endmodule

// File: rtl/dbg_port_activator.sv
module dbg_port_activator
    import dap_pkg::*;
#(
    parameter int HOLD_CYCLES  = 500,
    parameter int START_WINDOW = 20000,
    parameter int IDLE_LIMIT   = 20000,
    parameter int EDGE_TARGET  = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_clk_pin,
    input  logic dbg_data_pin,
    input  logic rst_sense_pin,
    output logic reset_function_enable,
    output logic interface_enabled,
    output logic sampled_reset
);

    localparam int MAX_A = (HOLD_CYCLES > START_WINDOW) ? HOLD_CYCLES : START_WINDOW;
    localparam int MAX_T = (MAX_A > IDLE_LIMIT) ? MAX_A : IDLE_LIMIT;
    localparam int TW    = (MAX_T > 1) ? $clog2(MAX_T + 1) : 1;
    localparam int EW    = $clog2(EDGE_TARGET + 1);

    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYCLES - 1);
    localparam logic [TW-1:0] WIN_LAST  = TW'(START_WINDOW - 1);
    localparam logic [TW-1:0] IDLE_LAST = TW'(IDLE_LIMIT - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_TARGET - 1);

    // Synchronised inputs: [0] debug clock, [1] data, [2] reset sense.
    logic [2:0] pins_s;
    logic       clk_s;
    logic       data_s;
    logic       sense_s;
    logic       clk_rise;

    dap_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({rst_sense_pin, dbg_data_pin, dbg_clk_pin}),
        .dout  (pins_s)
    );

    assign clk_s   = pins_s[0];
    assign data_s  = pins_s[1];
    assign sense_s = pins_s[2];

    dap_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (clk_s),
        .rise  (clk_rise)
    );

    dap_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [EW-1:0] edges_q, edges_d;
    logic          samp_q, samp_d;

    // Next-state and counter logic. Priority: data abort > edge > timer expiry.
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q + 1'b1;
        edges_d = edges_q;
        samp_d  = samp_q;
        unique case (state_q)
            ST_RESET_MODE: begin
                tmr_d   = '0;
                edges_d = '0;
                samp_d  = 1'b0;
                if (data_s) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!data_s) begin
                    state_d = ST_RESET_MODE;
                    tmr_d   = '0;
                end else if (tmr_q == HOLD_LAST) begin
                    state_d = ST_ARMED;
                    tmr_d   = '0;
                end
            end
            ST_ARMED: begin
                if (!data_s) begin
                    state_d = ST_RESET_MODE;
                    tmr_d   = '0;
                end else if (clk_rise) begin
                    state_d = ST_COUNT;
                    tmr_d   = '0;
                    edges_d = EW'(1);
                end else if (tmr_q == WIN_LAST) begin
                    state_d = ST_RESET_MODE;
                    tmr_d   = '0;
                end
            end
            ST_COUNT: begin
                if (!data_s) begin
                    state_d = ST_RESET_MODE;
                    tmr_d   = '0;
                end else if (clk_rise) begin
                    tmr_d = '0;
                    if (edges_q == EDGE_LAST) begin
                        state_d = ST_ENABLED;
                        samp_d  = sense_s;
                    end else begin
                        edges_d = edges_q + 1'b1;
                    end
                end else if (tmr_q == IDLE_LAST) begin
                    state_d = ST_RESET_MODE;
                    tmr_d   = '0;
                end
            end
            ST_ENABLED: begin
                if (clk_rise) begin
                    tmr_d = '0;
                end else if (tmr_q == IDLE_LAST) begin
                    state_d = ST_RESET_MODE;
                    tmr_d   = '0;
                    samp_d  = 1'b0;
                end
            end
            default: begin
                state_d = ST_RESET_MODE;
                tmr_d   = '0;
                edges_d = '0;
                samp_d  = 1'b0;
            end
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET_MODE;
            tmr_q   <= '0;
            edges_q <= '0;
            samp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            edges_q <= edges_d;
            samp_q  <= samp_d;
        end
    end

    // Output decode process.
    always_comb begin
        reset_function_enable = 1'b0;
        interface_enabled     = 1'b0;
        unique case (state_q)
            ST_RESET_MODE, ST_HOLD: reset_function_enable = 1'b1;
            ST_ENABLED:             interface_enabled     = 1'b1;
            default: begin
                reset_function_enable = 1'b0;
                interface_enabled     = 1'b0;
            end
        endcase
        sampled_reset = samp_q;
    end

endmodule

// File: rtl/dap_checker.sv
module dap_checker (
    input logic clk,
    input logic rst_n,
    input logic rfe,
    input logic ie,
    input logic sr,
    input logic data_s,
    input logic rise_s,
    input logic sense_s
);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfe && ie));

    assert_arm_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfe) |-> $past(data_s));

    assert_enable_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie) |-> $past(rise_s));

    assert_abort_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfe && !ie && !data_s) |=> rfe);

    assert_drop_to_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ie) |-> rfe);

    assert_capture_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie) |-> (sr == $past(sense_s)));

    assert_sample_only_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr |-> ie);

endmodule

bind dbg_port_activator dap_checker u_dap_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rfe     (reset_function_enable),
    .ie      (interface_enabled),
    .sr      (sampled_reset),
    .data_s  (data_s),
    .rise_s  (clk_rise),
    .sense_s (sense_s)
);

// File: tb/test_dbg_port_activator.sv
`timescale 1ns/1ps
module test_dbg_port_activator;

    localparam int HOLD = 20;
    localparam int WIN  = 60;
    localparam int IDLE = 30;
    localparam int EDG  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pclk = 1'b0;
    logic pdat = 1'b0;
    logic psense = 1'b0;
    logic rfe, ie, sr;

    always #2.5 clk = ~clk;

    dbg_port_activator #(
        .HOLD_CYCLES  (HOLD),
        .START_WINDOW (WIN),
        .IDLE_LIMIT   (IDLE),
        .EDGE_TARGET  (EDG),
        .SYNC_STAGES  (2)
    ) i_dbg_port_activator (
        .clk                   (clk),
        .rst_n                 (rst_n),
        .dbg_clk_pin           (pclk),
        .dbg_data_pin          (pdat),
        .rst_sense_pin         (psense),
        .reset_function_enable (rfe),
        .interface_enabled     (ie),
        .sampled_reset         (sr)
    );

    typedef struct {
        string tag;
        logic  rfe;
        logic  ie;
        logic  sr;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Monitor: pops expectations and compares at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (rfe !== e.rfe || ie !== e.ie || sr !== e.sr) begin
                n_fail++;
                $display("FAIL %s: got rfe=%0b en=%0b sr=%0b, expected rfe=%0b en=%0b sr=%0b",
                         e.tag, rfe, ie, sr, e.rfe, e.ie, e.sr);
            end
            n_chk++;
            if (rfe === 1'b1 && ie === 1'b1) begin
                n_fail++;
                $display("FAIL R9 (%s): got rfe=1 en=1, expected not both", e.tag);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_o(string tag, logic a, logic b, logic c);
        exp_t e;
        e.tag = tag;
        e.rfe = a;
        e.ie  = b;
        e.sr  = c;
        q.push_back(e);
    endtask

    task automatic pulses(int n, int period);
        for (int i = 0; i < n; i++) begin
            pclk = 1'b1;
            tick(2);
            pclk = 1'b0;
            tick(period - 2);
        end
    endtask

    task automatic arm();
        pdat = 1'b1;
        tick(HOLD + 10);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_o("R1 during reset", 1'b1, 1'b0, 1'b0);
        tick(1);
        rst_n = 1'b1;
        tick(2);
        expect_o("R1 after reset", 1'b1, 1'b0, 1'b0);

        // R2: short data-high request must not leave reset mode
        pdat = 1'b1;
        tick(15);
        pdat = 1'b0;
        tick(10);
        expect_o("R2 short hold", 1'b1, 1'b0, 1'b0);

        // R2 then R4: long hold arms, missing first edge re-enters reset mode
        pdat = 1'b1;
        tick(30);
        expect_o("R2 long hold", 1'b0, 1'b0, 1'b0);
        tick(65);
        expect_o("R4 window expired", 1'b1, 1'b0, 1'b0);
        pdat = 1'b0;
        tick(5);

        // R3: 15 edges not enough, 16th enables; R7 capture of sense=1
        psense = 1'b1;
        arm();
        pulses(EDG - 1, 10);
        expect_o("R3 one edge short", 1'b0, 1'b0, 1'b0);
        pulses(1, 10);
        expect_o("R3/R7 enabled with sense=1", 1'b0, 1'b1, 1'b1);

        // R8: data low while enabled is ignored
        pdat = 1'b0;
        pulses(3, 10);
        expect_o("R8 data low ignored", 1'b0, 1'b1, 1'b1);

        // R6/R7: clock stops, port drops, sample cleared
        tick(IDLE + 10);
        expect_o("R6/R7 inactivity in enabled", 1'b1, 1'b0, 1'b0);

        // R5: data low mid-count aborts
        arm();
        pulses(5, 10);
        pdat = 1'b0;
        tick(5);
        expect_o("R5 abort in count", 1'b1, 1'b0, 1'b0);
        pulses(EDG + 4, 10);
        expect_o("R5 edges with data low", 1'b1, 1'b0, 1'b0);

        // R6: edges exactly on timer expiry keep the sequence alive; sense=0
        psense = 1'b0;
        arm();
        pulses(EDG, IDLE);
        expect_o("R6 edge wins at expiry", 1'b0, 1'b1, 1'b0);
        pulses(3, IDLE);
        expect_o("R6 enabled at expiry spacing", 1'b0, 1'b1, 1'b0);
        pdat = 1'b0;
        tick(IDLE + 5);
        expect_o("R6 stop after boundary run", 1'b1, 1'b0, 1'b0);

        // R6: one cycle wider spacing never enables
        arm();
        pulses(EDG, IDLE + 1);
        pdat = 1'b0;
        tick(5);
        expect_o("R6 spacing one too wide", 1'b1, 1'b0, 1'b0);

        tick(2);
        done = 1;
        summary();
        $finish;
    end

endmodule